// File: doc/BRIEF.md
# Segment Descriptor Load Checker

This block loads one of a small set of segment registers from a 16-bit selector. When protection is on and the core is not running in virtual-8086 mode, the block takes the index field of the selector and checks it against the limit of a global descriptor table. It fetches the 8-byte descriptor over a simple memory read port and checks it for privilege, type and presence. If every check passes, it writes the descriptor's base, limit and attribute bits into a per-segment cache. In real or virtual-8086 mode it only records the selector and derives the base from it, with no memory access.

A request is a one-cycle `start_i` pulse. The block samples the target segment, the selector, the current privilege level and the table geometry with it. Completion is a one-cycle `done_o` pulse, and it comes with a fault code. Any fault leaves the cache untouched. A decoded read port shows the cached contents of any one segment.

Top module: `seg_load_unit`

## Requirements
- R1: After reset `done_o` is low, `fault_o` is 0 and every cached selector, base, limit and attribute reads as zero.
- R2: In real mode (`pe_i`=0) a request issues no memory read, raises `done_o` on the clock edge after acceptance with `fault_o`=0, stores the selector and sets the base to selector×16, and keeps the cached limit and attributes.
- R3: The protected path is taken only when `pe_i`=1 and `vm_i`=0; with `vm_i`=1 the request behaves as in R2.
- R4: On the protected path the byte offset is selector bits 15:3 times 8. An offset larger than `tbl_limit_i` gives `fault_o`=1 (general protection), and no memory read is issued for it.
- R5: Otherwise the descriptor is read as two 32-bit words: the low word at `tbl_base_i`+offset first, then the high word at that address plus 4.
- R6: With the stack segment (index `SS_IDX`, default 2) as target, the following raise code 1, checked in this order: a zero index, an executable descriptor (high bit 11), a non-writable descriptor (high bit 9 clear), and an RPL (selector bits 1:0) that differs from `cpl_i` or from the DPL (high bits 14:13). A clear present bit (high bit 15) then raises code 2 (stack fault).
- R7: For any other target, code 1 is raised only when both RPL and `cpl_i` exceed the DPL. After that, a clear present bit raises code 3 (not present).
- R8: On success the cached base is {high[31:24], high[7:0], low[31:16]} and the cached limit is {high[19:16], low[15:0]}.
- R9: When the granularity bit (high bit 23) is set, the cached limit is that 20-bit value shifted left by 12.
- R10: On success `rd_attr_o` holds, from bit 8 down to bit 0: default size (high 22), present, DPL (2 bits), system type (high 12), executable, direction/conforming (high 10), read/write and accessed (high 8).
- R11: A faulting request leaves every cache entry unchanged. Fault codes: 0 none, 1 general protection, 2 stack, 3 not present.
- R12: `done_o` is high for exactly one cycle per accepted request, and a `start_i` that arrives while a fetch is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse |
| seg_sel_i | input | SEG_W | Target segment index |
| selector_i | input | 16 | Selector to load |
| pe_i | input | 1 | Protection enabled |
| vm_i | input | 1 | Virtual-8086 mode |
| cpl_i | input | 2 | Current privilege level |
| tbl_base_i | input | ADDR_W | Descriptor table base address |
| tbl_limit_i | input | TLIM_W | Descriptor table byte limit |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | ADDR_W | Read address |
| mem_ack_i | input | 1 | Read data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 2 | Fault code, valid with done_o |
| rd_seg_i | input | SEG_W | Segment shown on the read port |
| rd_selector_o | output | 16 | Cached selector |
| rd_base_o | output | 32 | Cached base |
| rd_limit_o | output | 32 | Cached limit |
| rd_attr_o | output | 9 | Cached attribute bits |

## Verification
The hardest case to reach from the ports is a successful stack-segment load. It needs a non-zero index within the table limit and a present, writable, non-executable descriptor, with RPL, CPL and DPL all equal. Uniform random descriptors almost never line up like that. About half of the random descriptors are therefore built "friendly": the fields are tied to the request's RPL and CPL. Directed cases then break one condition at a time to reach each fault in its priority order. A request is also re-issued while a fetch is in flight, and the bench confirms that only one completion occurs and that the other segment's entry stays unchanged.

// File: rtl/seg_load_pkg.sv
// Shared types for the segment load unit.
// Assumes descriptors use the standard 8-byte protected-mode layout.
package seg_load_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_STK  = 2'd2,
        FLT_NP   = 2'd3
    } fault_e;

    typedef struct packed {
        logic       size;
        logic       present;
        logic [1:0] dpl;
        logic       sys;
        logic       exec;
        logic       dc;
        logic       rw;
        logic       accessed;
    } seg_attr_t;

    typedef struct packed {
        logic [15:0] sel;
        logic [31:0] base;
        logic [31:0] limit;
        seg_attr_t   attr;
    } seg_cache_t;

    localparam int DESC_WORD_BYTES = 4;
    localparam int SEL_INDEX_LSB   = 3;

endpackage

// File: rtl/seg_desc_check.sv
// Combinational descriptor decoder and protection checker.
// Takes the two fetched descriptor words and the latched request.
// Produces the fault code and the cache entry that a successful load writes.
// Assumes the selector index sits in bits 15:3 and the RPL in bits 1:0.
module seg_desc_check
    import seg_load_pkg::*;
(
    input  logic        is_ss_i,
    input  logic [15:0] selector_i,
    input  logic [1:0]  cpl_i,
    input  logic [31:0] desc_lo_i,
    input  logic [31:0] desc_hi_i,
    output fault_e      fault_o,
    output seg_cache_t  entry_o
);
    logic [12:0] idx;
    logic [1:0]  rpl;
    logic [19:0] lim20;
    seg_attr_t   attr;

    // Split the selector and the descriptor into named fields.
    always_comb begin
        idx           = selector_i[15:SEL_INDEX_LSB];
        rpl           = selector_i[1:0];
        lim20         = {desc_hi_i[19:16], desc_lo_i[15:0]};
        attr.size     = desc_hi_i[22];
        attr.present  = desc_hi_i[15];
        attr.dpl      = desc_hi_i[14:13];
        attr.sys      = desc_hi_i[12];
        attr.exec     = desc_hi_i[11];
        attr.dc       = desc_hi_i[10];
        attr.rw       = desc_hi_i[9];
        attr.accessed = desc_hi_i[8];
    end

    // Build the cache entry, scaling the limit when the granularity bit is set.
    always_comb begin
        entry_o.sel   = selector_i;
        entry_o.base  = {desc_hi_i[31:24], desc_hi_i[7:0], desc_lo_i[31:16]};
        entry_o.limit = desc_hi_i[23] ? {lim20, 12'h000} : {12'h000, lim20};
        entry_o.attr  = attr;
    end

    // Apply the stack-specific or the general checks in priority order.
    always_comb begin
        fault_o = FLT_NONE;
        if (is_ss_i) begin
            if (idx == '0)
                fault_o = FLT_GP;
            else if (attr.exec || !attr.rw)
                fault_o = FLT_GP;
            else if ((rpl != cpl_i) || (rpl != attr.dpl))
                fault_o = FLT_GP;
            else if (!attr.present)
                fault_o = FLT_STK;
        end else begin
            if ((rpl > attr.dpl) && (cpl_i > attr.dpl))
                fault_o = FLT_GP;
            else if (!attr.present)
                fault_o = FLT_NP;
        end
    end

endmodule

// File: rtl/seg_fetch_ctrl.sv
// Sequencer for the two-word descriptor fetch.
// It starts from idle when a protected-mode request passes the index check.
// It reads the low word, then the high word, and spends one cycle in a
// check state in which the caller commits the result.
// Assumes the memory holds the request until it returns mem_ack_i.
module seg_fetch_ctrl
    import seg_load_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic [ADDR_W-1:0] desc_addr_i,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [31:0]       desc_lo_o,
    output logic [31:0]       desc_hi_o,
    output logic              chk_o,
    output logic              idle_o
);
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD_LO = 2'd1,
        ST_RD_HI = 2'd2,
        ST_CHK   = 2'd3
    } fst_e;

    fst_e              state;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       lo_q;
    logic [31:0]       hi_q;

    // Step through the fetch and capture each returned word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch_i) begin
                        state  <= ST_RD_LO;
                        addr_q <= desc_addr_i;
                    end
                end
                ST_RD_LO: begin
                    if (mem_ack_i) begin
                        lo_q   <= mem_rdata_i;
                        addr_q <= addr_q + ADDR_W'(DESC_WORD_BYTES);
                        state  <= ST_RD_HI;
                    end
                end
                ST_RD_HI: begin
                    if (mem_ack_i) begin
                        hi_q  <= mem_rdata_i;
                        state <= ST_CHK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port and the status strobes from the state.
    always_comb begin
        mem_req_o  = (state == ST_RD_LO) || (state == ST_RD_HI);
        mem_addr_o = addr_q;
        desc_lo_o  = lo_q;
        desc_hi_o  = hi_q;
        chk_o      = (state == ST_CHK);
        idle_o     = (state == ST_IDLE);
    end

    // R5: the high-word read follows the low word, 4 bytes above it.
    p_hi_follows_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_LO && mem_ack_i) |=>
            (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(DESC_WORD_BYTES)));

endmodule

// File: rtl/seg_cache_bank.sv
// Per-segment cached descriptor registers with a single write port and a
// decoded read port.
// A full write replaces the whole entry. A partial write (real mode) updates
// only the selector and the base.
module seg_cache_bank
    import seg_load_pkg::*;
#(
    parameter int NSEG  = 6,
    parameter int SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_full_i,
    input  logic [SEG_W-1:0] wr_seg_i,
    input  seg_cache_t       wr_data_i,
    input  logic [SEG_W-1:0] rd_seg_i,
    output seg_cache_t       rd_entry_o
);
    seg_cache_t ent [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_ent
        // Hold one segment's cached descriptor.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[g] <= '0;
            end else if (wr_en_i && wr_seg_i == SEG_W'(g)) begin
                if (wr_full_i) begin
                    ent[g] <= wr_data_i;
                end else begin
                    ent[g].sel  <= wr_data_i.sel;
                    ent[g].base <= wr_data_i.base;
                end
            end
        end
    end

    // Select the entry shown on the read port; out-of-range indices read zero.
    always_comb begin
        rd_entry_o = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (rd_seg_i == SEG_W'(i)) rd_entry_o = ent[i];
        end
    end

    // R11: without a write, the shown entry cannot change.
    p_hold_without_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (!$stable(rd_seg_i) || $stable(rd_entry_o)));

endmodule

// File: rtl/seg_load_unit.sv
// Segment register loader: accepts a request, chooses the real or protected
// path, runs the index check, fetches and checks the descriptor, and commits
// to the cache or reports a fault.
// Assumes a single outstanding request; start_i while busy is dropped.
module seg_load_unit
    import seg_load_pkg::*;
#(
    parameter int NSEG   = 6,
    parameter int SS_IDX = 2,
    parameter int ADDR_W = 32,
    parameter int TLIM_W = 16,
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SEG_W-1:0]  seg_sel_i,
    input  logic [15:0]       selector_i,
    input  logic              pe_i,
    input  logic              vm_i,
    input  logic [1:0]        cpl_i,
    input  logic [ADDR_W-1:0] tbl_base_i,
    input  logic [TLIM_W-1:0] tbl_limit_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        fault_o,
    input  logic [SEG_W-1:0]  rd_seg_i,
    output logic [15:0]       rd_selector_o,
    output logic [31:0]       rd_base_o,
    output logic [31:0]       rd_limit_o,
    output logic [8:0]        rd_attr_o
);
    localparam int CMP_W = (ADDR_W > TLIM_W) ? ADDR_W : TLIM_W;

    logic              idle;
    logic              accept;
    logic              prot;
    logic              over;
    logic [CMP_W-1:0]  offset;
    logic [ADDR_W-1:0] desc_addr;
    logic              chk;
    logic [31:0]       desc_lo;
    logic [31:0]       desc_hi;
    fault_e            chk_fault;
    seg_cache_t        chk_entry;

    logic [SEG_W-1:0]  req_seg;
    logic [15:0]       req_sel;
    logic [1:0]        req_cpl;
    logic              done_q;
    fault_e            fault_q;

    logic              wr_en;
    logic              wr_full;
    logic [SEG_W-1:0]  wr_seg;
    seg_cache_t        wr_data;
    seg_cache_t        rd_entry;

    // Decide the path and run the table index check at acceptance.
    always_comb begin
        accept    = start_i && idle;
        prot      = pe_i && !vm_i;
        offset    = CMP_W'({selector_i[15:SEL_INDEX_LSB], 3'b000});
        over      = offset > CMP_W'(tbl_limit_i);
        desc_addr = tbl_base_i + ADDR_W'(offset);
    end

    seg_fetch_ctrl #(.ADDR_W(ADDR_W)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (accept && prot && !over),
        .desc_addr_i (desc_addr),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_req_o   (mem_req_o),
        .mem_addr_o  (mem_addr_o),
        .desc_lo_o   (desc_lo),
        .desc_hi_o   (desc_hi),
        .chk_o       (chk),
        .idle_o      (idle)
    );

    seg_desc_check u_check (
        .is_ss_i    (req_seg == SEG_W'(SS_IDX)),
        .selector_i (req_sel),
        .cpl_i      (req_cpl),
        .desc_lo_i  (desc_lo),
        .desc_hi_i  (desc_hi),
        .fault_o    (chk_fault),
        .entry_o    (chk_entry)
    );

    // Latch the request and produce the completion pulse and fault code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seg <= '0;
            req_sel <= '0;
            req_cpl <= '0;
            done_q  <= 1'b0;
            fault_q <= FLT_NONE;
        end else begin
            if (accept) begin
                req_seg <= seg_sel_i;
                req_sel <= selector_i;
                req_cpl <= cpl_i;
            end
            done_q <= (accept && (!prot || over)) || chk;
            if (accept && prot && over) fault_q <= FLT_GP;
            else if (chk)               fault_q <= chk_fault;
            else                        fault_q <= FLT_NONE;
        end
    end

    // Form the cache write: a partial write in real mode, a full write after a clean check.
    always_comb begin
        wr_en   = (accept && !prot) || (chk && chk_fault == FLT_NONE);
        wr_full = chk;
        wr_seg  = chk ? req_seg : seg_sel_i;
        if (chk) begin
            wr_data = chk_entry;
        end else begin
            wr_data       = '0;
            wr_data.sel   = selector_i;
            wr_data.base  = {12'h000, selector_i, 4'h0};
        end
    end

    seg_cache_bank #(.NSEG(NSEG), .SEG_W(SEG_W)) u_cache (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_full_i  (wr_full),
        .wr_seg_i   (wr_seg),
        .wr_data_i  (wr_data),
        .rd_seg_i   (rd_seg_i),
        .rd_entry_o (rd_entry)
    );

    // Drive the outputs.
    always_comb begin
        busy_o        = !idle;
        done_o        = done_q;
        fault_o       = fault_q;
        rd_selector_o = rd_entry.sel;
        rd_base_o     = rd_entry.base;
        rd_limit_o    = rd_entry.limit;
        rd_attr_o     = rd_entry.attr;
    end

    // R2/R4: requests on the real path or rejected by the index check never touch memory.
    p_reject_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (!prot || over)) |=> !mem_req_o);

    // R4: an index beyond the table limit completes next cycle with a GP fault.
    p_index_gp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && prot && over) |=> (done_o && fault_o == FLT_GP));

    // R6: a stack fault is only reported for the stack segment.
    p_stk_only_ss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == FLT_STK) |-> (req_seg == SEG_W'(SS_IDX)));

    // R7: a not-present fault is never reported for the stack segment.
    p_np_not_ss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o == FLT_NP) |-> (req_seg != SEG_W'(SS_IDX)));

    // R12: completion is a single-cycle pulse.
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/seg_load_unit_bench.sv
module seg_load_unit_bench;
    localparam int NSEG   = 6;
    localparam int SS     = 2;
    localparam int SEG_W  = 3;
    localparam int NDESC  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [SEG_W-1:0] seg_sel_i = '0;
    logic [15:0] selector_i = '0;
    logic        pe_i = 1'b0, vm_i = 1'b0;
    logic [1:0]  cpl_i = '0;
    logic [31:0] tbl_base_i = 32'h0000_4000;
    logic [15:0] tbl_limit_i = 16'h00FF;
    logic        mem_req_o, mem_ack_i;
    logic [31:0] mem_addr_o, mem_rdata_i;
    logic        busy_o, done_o;
    logic [1:0]  fault_o;
    logic [SEG_W-1:0] rd_seg_i = '0;
    logic [15:0] rd_selector_o;
    logic [31:0] rd_base_o, rd_limit_o;
    logic [8:0]  rd_attr_o;

    seg_load_unit #(.NSEG(NSEG), .SS_IDX(SS)) u_seg_load_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seg_sel_i(seg_sel_i),
        .selector_i(selector_i), .pe_i(pe_i), .vm_i(vm_i), .cpl_i(cpl_i),
        .tbl_base_i(tbl_base_i), .tbl_limit_i(tbl_limit_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
        .fault_o(fault_o), .rd_seg_i(rd_seg_i), .rd_selector_o(rd_selector_o),
        .rd_base_o(rd_base_o), .rd_limit_o(rd_limit_o), .rd_attr_o(rd_attr_o)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;

    logic [31:0] m_lo [NDESC];
    logic [31:0] m_hi [NDESC];
    logic [15:0] ms [NSEG];
    logic [31:0] mb [NSEG];
    logic [31:0] ml [NSEG];
    logic [8:0]  ma [NSEG];

    // Memory model: acknowledge at once, return the table word at the address.
    always_comb begin
        logic [31:0] rel;
        rel = mem_addr_o - tbl_base_i;
        mem_ack_i = mem_req_o;
        if ((rel >> 3) < NDESC)
            mem_rdata_i = rel[2] ? m_hi[rel[7:3]] : m_lo[rel[7:3]];
        else
            mem_rdata_i = 32'h0;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_hi(input logic [7:0] bhi, input logic g,
        input logic db, input logic [3:0] lhi, input logic p, input logic [1:0] dpl,
        input logic s, input logic ex, input logic dc, input logic rw, input logic a,
        input logic [7:0] bmid);
        return {bhi, g, db, 1'b0, 1'b0, lhi, p, dpl, s, ex, dc, rw, a, bmid};
    endfunction

    // Expected fault code from R4, R6 and R7.
    function automatic logic [1:0] exp_fault(input int seg, input logic [15:0] sel,
        input logic [1:0] cpl, input logic [15:0] lim, input logic [31:0] hi);
        logic [1:0] rpl, dpl;
        rpl = sel[1:0];
        dpl = hi[14:13];
        if ({13'h0, sel[15:3], 3'b000} > {16'h0, lim}) return 2'd1;
        if (seg == SS) begin
            if (sel[15:3] == 0) return 2'd1;
            if (hi[11] || !hi[9]) return 2'd1;
            if (rpl != cpl || rpl != dpl) return 2'd1;
            if (!hi[15]) return 2'd2;
        end else begin
            if (rpl > dpl && cpl > dpl) return 2'd1;
            if (!hi[15]) return 2'd3;
        end
        return 2'd0;
    endfunction

    task automatic check_entry(input string tag, input int seg);
        rd_seg_i = SEG_W'(seg);
        #1;
        check({tag, " sel"},   {16'h0, rd_selector_o}, {16'h0, ms[seg]});
        check({tag, " base"},  rd_base_o, mb[seg]);
        check({tag, " limit"}, rd_limit_o, ml[seg]);
        check({tag, " attr"},  {23'h0, rd_attr_o}, {23'h0, ma[seg]});
    endtask

    // Run one request and check fault, reads, the done pulse and the cache.
    task automatic op(input string tag, input int seg, input logic [15:0] sel,
        input logic pe, input logic vm, input logic [1:0] cpl, input logic [15:0] lim,
        input logic poke);
        int cyc, nrd, other, idx;
        logic [31:0] a0, a1, lo, hi, base_exp, off;
        logic [19:0] l20;
        logic [1:0] ef;
        logic prot;
        idx = int'(sel[15:3]);
        lo = (idx < NDESC) ? m_lo[idx] : 32'h0;
        hi = (idx < NDESC) ? m_hi[idx] : 32'h0;
        prot = pe && !vm;
        off = {13'h0, sel[15:3], 3'b000};
        ef = prot ? exp_fault(seg, sel, cpl, lim, hi) : 2'd0;
        @(negedge clk);
        seg_sel_i = SEG_W'(seg); selector_i = sel; pe_i = pe; vm_i = vm;
        cpl_i = cpl; tbl_limit_i = lim; start_i = 1'b1;
        @(negedge clk);
        other = (seg + 1) % NSEG;
        if (poke) begin
            start_i = 1'b1; seg_sel_i = SEG_W'(other); selector_i = ~sel;
        end else start_i = 1'b0;
        cyc = 0; nrd = 0; a0 = '0; a1 = '0;
        while (!done_o && cyc < 20) begin
            if (mem_req_o) begin
                if (nrd == 0) a0 = mem_addr_o; else a1 = mem_addr_o;
                nrd++;
            end
            @(negedge clk);
            start_i = 1'b0; seg_sel_i = SEG_W'(seg); selector_i = sel;
            cyc++;
        end
        check({tag, " done seen (R12)"}, {31'h0, done_o}, 32'h1);
        check({tag, " fault code (R11)"}, {30'h0, fault_o}, {30'h0, ef});
        if (prot && off <= {16'h0, lim}) begin
            check({tag, " read count (R5)"}, nrd, 2);
            check({tag, " low addr (R5)"}, a0, tbl_base_i + off);
            check({tag, " high addr (R5)"}, a1, tbl_base_i + off + 32'd4);
        end else begin
            check({tag, " no read (R2 R4)"}, nrd, 0);
            if (!prot) check({tag, " real latency (R2 R3)"}, cyc, 0);
        end
        if (ef == 2'd0) begin
            if (!prot) begin
                ms[seg] = sel;
                mb[seg] = {12'h0, sel, 4'h0};
            end else begin
                l20 = {hi[19:16], lo[15:0]};
                base_exp = {hi[31:24], hi[7:0], lo[31:16]};
                ms[seg] = sel; mb[seg] = base_exp;
                ml[seg] = hi[23] ? {l20, 12'h0} : {12'h0, l20};
                ma[seg] = {hi[22], hi[15], hi[14:13], hi[12], hi[11], hi[10], hi[9], hi[8]};
            end
        end
        check_entry({tag, " target entry (R8 R9 R10 R11)"}, seg);
        @(negedge clk);
        check({tag, " done single (R12)"}, {31'h0, done_o}, 32'h0);
        check_entry({tag, " other entry (R11 R12)"}, other);
    endtask

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NSEG; i++) begin
            ms[i] = '0; mb[i] = '0; ml[i] = '0; ma[i] = '0;
        end
        for (int i = 0; i < NDESC; i++) begin
            m_lo[i] = $urandom;
            m_hi[i] = mk_hi(8'(i), 1'b0, 1'b1, 4'h0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1 done after reset", {31'h0, done_o}, 32'h0);
        check("R1 fault after reset", {30'h0, fault_o}, 32'h0);
        for (int s = 0; s < NSEG; s++) check_entry("R1 reset entry", s);

        // R2: real mode path.
        op("R2 real", 0, 16'h1234, 1'b0, 1'b0, 2'd0, 16'hFF, 1'b0);
        op("R2 real max", SS, 16'hFFFF, 1'b0, 1'b0, 2'd3, 16'h0, 1'b0);
        // R3: virtual-8086 takes the real path even with protection on.
        op("R3 v86", 1, 16'hB800, 1'b1, 1'b1, 2'd3, 16'h0, 1'b0);
        // R4: index beyond the limit, and the last index that fits.
        op("R4 over limit", 3, 16'h0010, 1'b1, 1'b0, 2'd0, 16'h000F, 1'b0);
        op("R4 at limit", 3, 16'h0008, 1'b1, 1'b0, 2'd0, 16'h000F, 1'b0);
        // R6: stack segment checks.
        op("R6 ss null", SS, 16'h0000, 1'b1, 1'b0, 2'd0, 16'hFF, 1'b0);
        m_hi[3] = mk_hi(8'h12, 1'b0, 1'b1, 4'h3, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h34);
        op("R6 ss exec", SS, 16'h0018, 1'b1, 1'b0, 2'd0, 16'hFF, 1'b0);
        m_hi[3] = mk_hi(8'h12, 1'b0, 1'b1, 4'h3, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h34);
        op("R6 ss readonly", SS, 16'h0018, 1'b1, 1'b0, 2'd0, 16'hFF, 1'b0);
        m_hi[3] = mk_hi(8'h12, 1'b0, 1'b1, 4'h3, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h34);
        op("R6 ss rpl vs cpl", SS, 16'h0019, 1'b1, 1'b0, 2'd0, 16'hFF, 1'b0);
        op("R6 ss rpl vs dpl", SS, 16'h001A, 1'b1, 1'b0, 2'd2, 16'hFF, 1'b0);
        m_hi[3] = mk_hi(8'h12, 1'b0, 1'b1, 4'h3, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h34);
        op("R6 ss not present", SS, 16'h0019, 1'b1, 1'b0, 2'd1, 16'hFF, 1'b0);
        m_hi[3] = mk_hi(8'h12, 1'b0, 1'b1, 4'h3, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h34);
        op("R6 ss ok", SS, 16'h0019, 1'b1, 1'b0, 2'd1, 16'hFF, 1'b0);
        // R7: other segments.
        m_hi[4] = mk_hi(8'hAB, 1'b0, 1'b0, 4'h1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hCD);
        op("R7 rpl above only", 0, 16'h0023, 1'b1, 1'b0, 2'd0, 16'hFF, 1'b0);
        op("R7 both above", 0, 16'h0023, 1'b1, 1'b0, 2'd2, 16'hFF, 1'b0);
        op("R7 null index other", 4, 16'h0000, 1'b1, 1'b0, 2'd0, 16'hFF, 1'b0);
        m_hi[4] = mk_hi(8'hAB, 1'b0, 1'b0, 4'h1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hCD);
        op("R7 not present", 5, 16'h0020, 1'b1, 1'b0, 2'd3, 16'hFF, 1'b0);
        // R8 R9: base assembly and granularity scaling.
        m_lo[5] = 32'h5678_BCDE;
        m_hi[5] = mk_hi(8'h9A, 1'b1, 1'b1, 4'hA, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h34);
        op("R9 granular", 1, 16'h0028, 1'b1, 1'b0, 2'd0, 16'hFF, 1'b0);
        check("R8 base value", mb[1], 32'h9A34_5678);
        check("R9 limit value", ml[1], 32'hABCD_E000);
        // R12: a start during a fetch is ignored.
        m_hi[6] = mk_hi(8'h01, 1'b0, 1'b1, 4'h0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02);
        op("R12 busy start", 3, 16'h0030, 1'b1, 1'b0, 2'd0, 16'hFF, 1'b1);

        // Random mix; about half the descriptors are built to pass the checks.
        for (int n = 0; n < 400; n++) begin
            int seg, idx;
            logic [1:0] cpl, rpl, dpl;
            logic [15:0] lim;
            logic pe, vm;
            seg = $urandom % NSEG;
            idx = $urandom % NDESC;
            cpl = 2'($urandom);
            rpl = ($urandom % 2) ? cpl : 2'($urandom);
            pe  = ($urandom % 5) != 0;
            vm  = ($urandom % 7) == 0;
            lim = ($urandom % 2) ? 16'h00FF : 16'($urandom % 256);
            r = $urandom;
            if ($urandom % 2) begin
                dpl = rpl;
                m_hi[idx] = mk_hi(8'(r), r[8], r[9], r[13:10], 1'b1, dpl, 1'b1, 1'b0,
                                  r[14], 1'b1, r[15], 8'(r >> 16));
            end else begin
                m_hi[idx] = $urandom;
                if ($urandom % 5 != 0) m_hi[idx][15] = 1'b1;
            end
            m_lo[idx] = $urandom;
            op("R6 R7 R8 R10 random", seg, {13'(idx), 1'b0, rpl}, pe, vm, cpl, lim, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule